// File: doc/BRIEF.md
# ARINC 429 Transmit Serializer

This block takes 32-bit ARINC 429 words from a host in two 16-bit writes, queues them, and sends them out as a return-to-zero bipolar signal split across two logic lines. One line pulses for a one bit and the other pulses for a zero bit. An external line driver turns this pair into the differential bus signal. The bit clock is derived from the master clock by a free-running divider. The divider ratio is 10 for the fast rate and 80 for the slow rate.

The host latches the first half with one strobe and the second half with another. The word is assembled and pushed into the queue on the second strobe. A mode input picks one of two orders for placing bus bits into word bits. Word bit 32 can go out as loaded or be replaced by a computed odd or even parity bit. The queue reports empty, half-full and full. A ready flag tells the host when everything it loaded has left the line. Words are sent only while the enable input is high, and at least four null bit times separate consecutive words.

Top module: `a429_tx_serializer`

## Requirements
- R1: With `linear_map`=1, the word formed by a `load_lo` write followed by a `load_hi` write uses these positions: the `load_lo` value gives word bits 1–16 (bus bit 0 is word bit 1) and the `load_hi` value gives bits 17–32. The word is queued on the `load_hi` strobe.
- R2: With `linear_map`=0, the `load_lo` value places its bits as follows. Bus bits 0–7 carry word bits 8,7,…,1 (bus bit 7 is word bit 1). Bus bit 8 is word bit 32. Bus bits 9 and 10 are word bits 30 and 31. Bus bits 11 and 12 are word bits 9 and 10. Bus bits 13–15 are word bits 11–13. The `load_hi` bus bits 0–15 carry word bits 14–29.
- R3: The queue holds 32 words and sends them in write order. `full_n` is low exactly when 32 words are held. A `load_hi` write while full is discarded and leaves the queue unchanged.
- R4: `half_full_n` is low when 16 or more words are held.
- R5: `fifo_empty` is high exactly when the queue holds no words.
- R6: One bit time lasts 10 clock cycles when `slow_rate`=0 and 80 cycles when `slow_rate`=1. The active line is high for the first half of the bit time and low for the second half. `bit_clk` is high during the first half of each bit time.
- R7: With `par_en`=0, bit 32 is sent as loaded. With `par_en`=1, bit 32 is replaced so that the 32-bit word has an odd count of ones when `par_even`=0, or an even count when `par_even`=1.
- R8: Between the start of the last bit of one word and the start of the first bit of the next word there are at least 5 bit times. This gives at least 4 null bit times.
- R9: A word starts only while `tx_en` is high. Dropping `tx_en` during a word lets that word finish but starts no further word.
- R10: `tx_ready` is high after reset and goes low on an accepted write. It returns high at the end of the last bit of a word when the queue is then empty.
- R11: Word bits go out in order from bit 1 to bit 32. A one pulses `line_one` and a zero pulses `line_zero`.
- R12: Both lines are low during nulls and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_in | input | 16 | Host write data |
| load_lo | input | 1 | Latch first half (one-cycle strobe) |
| load_hi | input | 1 | Latch second half and queue the word |
| tx_en | input | 1 | Allow new words to start |
| slow_rate | input | 1 | 0: divide by 10, 1: divide by 80 |
| par_en | input | 1 | Replace bit 32 with parity |
| par_even | input | 1 | 0: odd parity, 1: even parity |
| linear_map | input | 1 | Selects bus-to-word bit order |
| line_one | output | 1 | Return-to-zero pulse for a one bit |
| line_zero | output | 1 | Return-to-zero pulse for a zero bit |
| bit_clk | output | 1 | Free-running bit clock |
| fifo_empty | output | 1 | Queue empty |
| half_full_n | output | 1 | Low at 16 or more words |
| full_n | output | 1 | Low at 32 words |
| tx_ready | output | 1 | High when all loaded words have been sent |

## Verification
The assertions assume that `load_lo` and `load_hi` are single-cycle strobes. They also assume that `slow_rate`, `par_en` and `par_even` stay constant while a word is on the line, because the divider follows the rate input live and parity is computed when a word leaves the queue. The stimulus changes those settings only after `tx_ready` has returned high and a full gap has passed. It always issues the low-half strobe one cycle before the high-half strobe.

// File: rtl/a429_tx_serializer.sv
module a429_tx_serializer #(
  parameter int FIFO_DEPTH = 32,
  parameter int FAST_DIV   = 10,
  parameter int SLOW_DIV   = 80,
  parameter int GAP_BITS   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] bus_in,
  input  logic        load_lo,
  input  logic        load_hi,
  input  logic        tx_en,
  input  logic        slow_rate,
  input  logic        par_en,
  input  logic        par_even,
  input  logic        linear_map,
  output logic        line_one,
  output logic        line_zero,
  output logic        bit_clk,
  output logic        fifo_empty,
  output logic        half_full_n,
  output logic        full_n,
  output logic        tx_ready
);
  localparam int AW = $clog2(FIFO_DEPTH);
  localparam int CW = $clog2(FIFO_DEPTH + 1);
  localparam int PW = $clog2(SLOW_DIV);
  localparam int GW = $clog2(GAP_BITS + 1);
  localparam logic [CW-1:0] DEPTH_C = CW'(FIFO_DEPTH);
  localparam logic [CW-1:0] HALF_C  = CW'(FIFO_DEPTH / 2);

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_GAP} tx_state_t;

  function automatic logic [31:0] assemble(input logic [15:0] lo, input logic [15:0] hi,
                                           input logic lin);
    logic [31:0] w;
    if (lin) begin
      w = {hi, lo};
    end else begin
      w = '0;
      for (int k = 0; k < 8; k++) w[k] = lo[7-k];
      w[31]    = lo[8];
      w[29]    = lo[9];
      w[30]    = lo[10];
      w[9:8]   = lo[12:11];
      w[12:10] = lo[15:13];
      w[28:13] = hi;
    end
    return w;
  endfunction

  logic [15:0]   lo_hold;
  logic [31:0]   mem [FIFO_DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic [PW-1:0] phase, div_m1, half_mark;
  logic [31:0]   shreg, head, word_out;
  logic [4:0]    bit_cnt;
  logic [GW-1:0] gap_cnt;
  tx_state_t     state;
  logic          tick, push, pop, launch, sending, head_par, gap_done, last_bit;

  assign div_m1    = slow_rate ? PW'(SLOW_DIV - 1) : PW'(FAST_DIV - 1);
  assign half_mark = slow_rate ? PW'(SLOW_DIV / 2) : PW'(FAST_DIV / 2);
  assign tick      = (phase >= div_m1);
  assign bit_clk   = (phase < half_mark);

  assign push     = load_hi && (count != DEPTH_C);
  assign sending  = (state == ST_SEND);
  assign gap_done = (state == ST_GAP) && (gap_cnt == GW'(GAP_BITS - 1));
  assign last_bit = sending && (bit_cnt == 5'd31);
  assign launch   = tick && tx_en && (count != '0) && ((state == ST_IDLE) || gap_done);
  assign pop      = launch;

  assign head     = mem[rd_ptr];
  assign head_par = par_even ? ^head[30:0] : ~^head[30:0];
  assign word_out = par_en ? {head_par, head[30:0]} : head;

  assign fifo_empty  = (count == '0);
  assign half_full_n = (count < HALF_C);
  assign full_n      = (count != DEPTH_C);
  assign line_one    = sending && shreg[0]  && bit_clk;
  assign line_zero   = sending && !shreg[0] && bit_clk;

  always_ff @(posedge clk) begin
    if (load_lo) lo_hold <= bus_in;
    if (push) mem[wr_ptr] <= assemble(lo_hold, bus_in, linear_map);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(FIFO_DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == AW'(FIFO_DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= '0;
    else        phase <= tick ? '0 : phase + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      shreg   <= '0;
      bit_cnt <= '0;
      gap_cnt <= '0;
    end else if (launch) begin
      state   <= ST_SEND;
      shreg   <= word_out;
      bit_cnt <= '0;
    end else if (tick) begin
      case (state)
        ST_SEND: begin
          if (last_bit) begin
            state   <= ST_GAP;
            gap_cnt <= '0;
          end else begin
            shreg   <= shreg >> 1;
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        ST_GAP: begin
          if (gap_done) state <= ST_IDLE;
          else          gap_cnt <= gap_cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                               tx_ready <= 1'b1;
    else if (push)                            tx_ready <= 1'b0;
    else if (tick && last_bit && count == '0) tx_ready <= 1'b1;
  end
endmodule

// File: rtl/a429_tx_chk.sv
module a429_tx_chk #(
  parameter int FIFO_DEPTH = 32,
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load_hi,
  input logic          tx_en,
  input logic          line_one,
  input logic          line_zero,
  input logic          bit_clk,
  input logic          full_n,
  input logic          tx_ready,
  input logic          sending,
  input logic          pop,
  input logic [CW-1:0] count
);
  assert_never_both_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_one && line_zero));

  assert_null_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !sending |-> (!line_one && !line_zero));

  assert_rz_first_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (line_one || line_zero) |-> bit_clk);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && load_hi && !pop) |=> (count == $past(count)));

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(FIFO_DEPTH));

  assert_ready_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (load_hi && full_n) |=> !tx_ready);

  assert_enable_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sending && !tx_en) |=> !sending);
endmodule

bind a429_tx_serializer a429_tx_chk #(.FIFO_DEPTH(FIFO_DEPTH), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .load_hi(load_hi), .tx_en(tx_en),
  .line_one(line_one), .line_zero(line_zero), .bit_clk(bit_clk),
  .full_n(full_n), .tx_ready(tx_ready), .sending(sending), .pop(pop), .count(count)
);

// File: tb/a429_tx_serializer_tb_top.sv
module a429_tx_serializer_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic [15:0] bus_in;
  logic load_lo, load_hi, tx_en, slow_rate, par_en, par_even, linear_map;
  logic line_one, line_zero, bit_clk, fifo_empty, half_full_n, full_n, tx_ready;

  always #5 clk = ~clk;

  a429_tx_serializer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .load_lo(load_lo), .load_hi(load_hi),
    .tx_en(tx_en), .slow_rate(slow_rate), .par_en(par_en), .par_even(par_even),
    .linear_map(linear_map), .line_one(line_one), .line_zero(line_zero),
    .bit_clk(bit_clk), .fifo_empty(fifo_empty), .half_full_n(half_full_n),
    .full_n(full_n), .tx_ready(tx_ready)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  int mon_div = 10;
  bit have_prev = 0;
  int rises = 0;
  int words_done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [15:0] lo, input logic [15:0] hi,
                                        input logic lin, input logic pen, input logic peven);
    logic [31:0] w;
    int ones;
    if (lin) w = {hi, lo};
    else begin
      w = '0;
      for (int b = 1; b <= 8; b++) w[b-1] = lo[8-b];
      w[31] = lo[8];
      w[29] = lo[9];
      w[30] = lo[10];
      for (int b = 9; b <= 13; b++) w[b-1] = lo[b+2];
      for (int b = 14; b <= 29; b++) w[b-1] = hi[b-14];
    end
    if (pen) begin
      ones = 0;
      for (int b = 0; b < 31; b++) ones += int'(w[b]);
      w[31] = peven ? logic'(ones % 2 == 1) : logic'(ones % 2 == 0);
    end
    return w;
  endfunction

  task automatic send_word(input logic [15:0] lo, input logic [15:0] hi,
                           input string tag, input bit accepted);
    @(negedge clk);
    bus_in = lo; load_lo = 1'b1;
    @(negedge clk);
    load_lo = 1'b0; bus_in = hi; load_hi = 1'b1;
    if (accepted) begin
      exp_q.push_back(model(lo, hi, linear_map, par_en, par_even));
      tag_q.push_back(tag);
    end
    @(negedge clk);
    load_hi = 1'b0;
  endtask

  task automatic drain();
    while (!(exp_q.size() == 0 && tx_ready)) @(negedge clk);
    repeat (6 * mon_div) @(negedge clk);
  endtask

  // scoreboard monitor
  logic p1 = 1'b0, p0 = 1'b0;
  int cyc = 0, last_rise = 0, high_start = 0, bit_idx = 0;
  bit timing_bad = 0;
  logic [31:0] rx;
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      cyc++;
      if ((line_one && !p1) || (line_zero && !p0)) begin
        rises++;
        if (line_one && line_zero) timing_bad = 1;
        if (bit_idx == 0) begin
          if (have_prev) chk((cyc - last_rise) >= 5 * mon_div, "R8 word gap",
                             32'(cyc - last_rise), 32'(5 * mon_div));
        end else if ((cyc - last_rise) != mon_div) timing_bad = 1;
        last_rise  = cyc;
        high_start = cyc;
        rx[bit_idx] = line_one;
        bit_idx++;
        if (bit_idx == 32) begin
          bit_idx = 0;
          words_done++;
          have_prev = 1;
          if (exp_q.size() == 0) chk(0, "R3 unexpected extra word", rx, 32'h0);
          else begin
            automatic logic [31:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            chk(rx === e, t, rx, e);
          end
          chk(!timing_bad, "R6 bit timing", 32'(timing_bad), 32'h0);
          timing_bad = 0;
        end
      end
      if ((!line_one && p1) || (!line_zero && p0))
        if ((cyc - high_start) != mon_div / 2) timing_bad = 1;
      p1 = line_one;
      p0 = line_zero;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    rst_n = 1'b0; bus_in = '0; load_lo = 0; load_hi = 0; tx_en = 0;
    slow_rate = 0; par_en = 0; par_even = 0; linear_map = 1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fifo_empty == 1, "R5 reset empty", 32'(fifo_empty), 1);
    chk(half_full_n == 1, "R4 reset half", 32'(half_full_n), 1);
    chk(full_n == 1, "R3 reset full", 32'(full_n), 1);
    chk(tx_ready == 1, "R10 reset ready", 32'(tx_ready), 1);
    chk(!line_one && !line_zero, "R12 reset lines", {line_one, line_zero}, 0);

    // R9: disabled, nothing leaves
    send_word(16'h1234, 16'h8765, "R1 linear word", 1);
    chk(fifo_empty == 0, "R5 not empty", 32'(fifo_empty), 0);
    chk(tx_ready == 0, "R10 ready low after write", 32'(tx_ready), 0);
    repeat (300) @(negedge clk);
    chk(rises == 0, "R9 no output while disabled", rises, 0);
    tx_en = 1;
    drain();
    chk(tx_ready == 1, "R10 ready after drain", 32'(tx_ready), 1);
    chk(fifo_empty == 1, "R5 empty after drain", 32'(fifo_empty), 1);

    // R1 / R11 linear patterns
    send_word(16'h0001, 16'h8000, "R11 first and last bit", 1);
    send_word(16'hA5C3, 16'h0F81, "R1 linear pattern", 1);
    send_word(16'hFFFF, 16'h0000, "R11 ones then zeros", 1);
    drain();

    // R2 alternate order
    linear_map = 0;
    send_word(16'h0080, 16'h0000, "R2 bus7 to bit1", 1);
    send_word(16'h0100, 16'h0000, "R2 bus8 to bit32", 1);
    send_word(16'h0600, 16'h0000, "R2 bits 30 31", 1);
    send_word(16'h1801, 16'h0000, "R2 bits 9 10 and bit8", 1);
    send_word(16'hE000, 16'hFFFF, "R2 bits 11-13 and 14-29", 1);
    send_word(16'h5A3C, 16'hC3A5, "R2 mixed", 1);
    drain();

    // R7 parity
    linear_map = 1; par_en = 1; par_even = 0;
    send_word(16'h0003, 16'h8000, "R7 odd parity", 1);
    send_word(16'h0007, 16'h0000, "R7 odd parity b", 1);
    drain();
    par_even = 1;
    send_word(16'h0003, 16'h0000, "R7 even parity", 1);
    send_word(16'h0001, 16'h8000, "R7 even parity b", 1);
    drain();
    par_en = 0;

    // R9 enable dropped mid-word
    tx_en = 0;
    send_word(16'h1111, 16'h2222, "R9 first word", 1);
    send_word(16'h3333, 16'h4444, "R9 second word", 1);
    base = words_done;
    tx_en = 1;
    repeat (30) @(negedge clk);
    tx_en = 0;
    repeat (600) @(negedge clk);
    chk(words_done == base + 1, "R9 only started word finishes", words_done - base, 1);
    chk(fifo_empty == 0, "R9 second word held", 32'(fifo_empty), 0);
    tx_en = 1;
    drain();

    // R3 / R4 fill, overflow, ordered drain
    tx_en = 0;
    for (int i = 0; i < 32; i++) begin
      send_word(16'(i * 37 + 5), 16'(16'hB000 + i), "R3 ordered fill", 1);
      if (i == 14) chk(half_full_n == 1, "R4 15 words", 32'(half_full_n), 1);
      if (i == 15) chk(half_full_n == 0, "R4 16 words", 32'(half_full_n), 0);
      if (i == 30) chk(full_n == 1, "R3 31 words", 32'(full_n), 1);
    end
    chk(full_n == 0, "R3 32 words full", 32'(full_n), 0);
    send_word(16'hDEAD, 16'hBEEF, "R3 dropped", 0);
    chk(full_n == 0, "R3 still full after drop", 32'(full_n), 0);
    tx_en = 1;
    drain();

    // R6 slow rate
    slow_rate = 1; mon_div = 80; have_prev = 0;
    repeat (200) @(negedge clk);
    send_word(16'h9C31, 16'h4E27, "R6 slow word", 1);
    send_word(16'h0F0F, 16'hF0F0, "R6 slow word b", 1);
    drain();

    chk(exp_q.size() == 0, "R3 all words sent", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule